// File: doc/BRIEF.md
# Fluorescent Display Refresh Scanner

This block refreshes a multiplexed vacuum fluorescent display from a byte-wide display RAM that it shares with a CPU. The frame has sixteen digit slots followed by one key-scan slot. In each digit slot the block drives 40 segment lines and asserts one digit line. The five segment bytes for a slot are read from the RAM during the slot before it and held in a shadow register. At the slot boundary the whole set moves to the outputs at once.

In the key-scan slot every segment and digit line goes low. The shared pin bus then carries the general-purpose port latch values instead of segment data, so external key-matrix logic can use the same pins. The CPU reads and writes the RAM through a valid/ready request channel.

Display fetches have priority on the single RAM port. A CPU request seen during a fetch cycle is held off with ready low and must be held stable by the requester until it is accepted. Read data comes back on a response strobe one cycle after acceptance. The response path has no back-pressure; the requester must always take it.

Top module: `vfd_scan_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, and until the first slot boundary after it is released, seg_o, dig_o, key_o, pin_o and cpu_rvalid are all 0. The first displayed slot after reset is T0.
- R2: Every slot lasts max(slot_len, 5) + 1 clock cycles.
- R3: Slots run in the order T0, T1 … T15, then the key-scan slot, and then the order repeats. During Tn, dig_o equals 1 << n. During the key-scan slot, dig_o is 0 and key_o is 1. At most one digit bit is ever set.
- R4: During Tn, segment byte g (g = 0..4, covering seg_o[8g+7:8g]) holds the RAM byte at address 0xFA30 + 16·g + n. Byte bit b drives seg_o[8g+b].
- R5: During the key-scan slot, seg_o is 0 and pin_o equals port_lat. In every other slot, pin_o equals seg_o.
- R6: In the first five cycles of any slot that is followed by a digit slot, the block fetches from the RAM and holds cpu_ready low. In all other cycles cpu_ready is 1.
- R7: A request accepted with cpu_we=1 at an address from 0xFA30 to 0xFA7F writes that RAM byte. A request accepted with cpu_we=0 returns the byte on cpu_rdata, with cpu_rvalid high, in the next cycle.
- R8: Segment and digit outputs change only at slot boundaries. A CPU write to a byte that is already in the shadow register does not show until that byte is fetched again.
- R9: A request outside 0xFA30 to 0xFA7F is accepted but changes no RAM byte. If it is a read, it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_len | input | 8 | Slot length count; slot is max(slot_len,5)+1 cycles |
| port_lat | input | 40 | General-purpose port latch values shown in the key-scan slot |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | CPU request accepted this cycle when high with valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a read is accepted |
| cpu_rdata | output | 8 | Read data |
| seg_o | output | 40 | Segment outputs |
| dig_o | output | 16 | One-hot digit outputs |
| key_o | output | 1 | High during the key-scan slot |
| pin_o | output | 40 | Shared pins: segment data or port latch values |

## Verification
A display fetch and a CPU request can both want the single RAM port in the same cycle. The bench provokes this by holding a read request valid through two whole frames. In every cycle of those frames it compares cpu_ready with a model of the fetch window: stalled in the first five cycles of any slot that precedes a digit slot, free otherwise. Meanwhile a scoreboard checks that each slot still shows the correct bytes and length, so the fetches are shown to be undisturbed by the waiting CPU.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  parameter int DIGITS   = 16;
  parameter int GROUPS   = 5;
  parameter int BYTE_W   = 8;
  parameter int ADDR_W   = 16;
  parameter int CNT_W    = 8;
  parameter logic [15:0] RAM_BASE = 16'hFA30;
  localparam int SEG_W   = GROUPS * BYTE_W;
  localparam int RAM_N   = DIGITS * GROUPS;
  localparam int SLOT_W  = $clog2(DIGITS + 1);
  localparam int GRP_W   = $clog2(GROUPS);
  localparam int DIG_IW  = $clog2(DIGITS);
endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer
  import vfd_pkg::*;
#(
  parameter int NDIG = DIGITS,
  parameter int NGRP = GROUPS,
  parameter int CW   = CNT_W,
  localparam int SW  = $clog2(NDIG + 1),
  localparam int GW  = $clog2(NGRP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] slot_len,
  output logic          tick,
  output logic [SW-1:0] nxt_slot,
  output logic          fetch_en,
  output logic [GW-1:0] fetch_grp
);
  localparam logic [SW-1:0] KEY_SLOT = SW'(NDIG);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic [SW-1:0] cur_slot;

  assign limit     = (slot_len < CW'(NGRP)) ? CW'(NGRP) : slot_len;
  assign tick      = (cnt >= limit);
  assign nxt_slot  = (cur_slot == KEY_SLOT) ? '0 : cur_slot + SW'(1);
  assign fetch_en  = (cnt < CW'(NGRP)) && (nxt_slot != KEY_SLOT);
  assign fetch_grp = GW'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cur_slot <= KEY_SLOT;
    end else if (tick) begin
      cnt      <= '0;
      cur_slot <= nxt_slot;
    end else begin
      cnt      <= cnt + CW'(1);
    end
  end

  // R6: the shadow set is complete before any transfer
  p_fetch_done_r6: assert property (@(posedge clk) disable iff (rst)
    tick |-> !fetch_en);

  // R2: a new slot begins counting from zero
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));
endmodule

// File: rtl/vfd_disp_ram.sv
module vfd_disp_ram
  import vfd_pkg::*;
#(
  parameter int NDIG = DIGITS,
  parameter int NGRP = GROUPS,
  parameter int AW   = ADDR_W,
  parameter int BW   = BYTE_W,
  parameter logic [15:0] BASE = RAM_BASE,
  localparam int MEMN = NDIG * NGRP,
  localparam int IW   = $clog2(MEMN),
  localparam int GW   = $clog2(NGRP),
  localparam int DW   = $clog2(NDIG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [BW-1:0] cpu_wdata,
  output logic          cpu_rvalid,
  output logic [BW-1:0] cpu_rdata,
  input  logic          fetch_en,
  input  logic [GW-1:0] fetch_grp,
  input  logic [DW-1:0] fetch_dig,
  output logic [BW-1:0] fetch_data
);
  logic [BW-1:0] mem [MEMN];
  logic [AW-1:0] offset;
  logic          in_rng;
  logic          accept;
  logic [IW-1:0] fetch_idx;
  logic [IW-1:0] port_idx;
  logic [BW-1:0] port_rd;

  assign offset     = cpu_addr - AW'(BASE);
  assign in_rng     = (cpu_addr >= AW'(BASE)) && (offset < AW'(MEMN));
  assign cpu_ready  = !fetch_en;
  assign accept     = cpu_valid && cpu_ready;
  assign fetch_idx  = IW'(fetch_grp) * IW'(NDIG) + IW'(fetch_dig);
  assign port_idx   = fetch_en ? fetch_idx : IW'(offset);
  assign port_rd    = mem[port_idx];
  assign fetch_data = port_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= '0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      cpu_rvalid <= accept && !cpu_we;
      if (accept && !cpu_we) cpu_rdata <= in_rng ? port_rd : '0;
      if (accept && cpu_we && in_rng) mem[port_idx] <= cpu_wdata;
    end
  end

  p_fetch_wins_r6: assert property (@(posedge clk) disable iff (rst)
    fetch_en |-> !cpu_ready);

  p_read_resp_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && !cpu_we) |=> cpu_rvalid);

  p_write_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && cpu_we) |=> !cpu_rvalid);
endmodule

// File: rtl/vfd_seg_latch.sv
module vfd_seg_latch
  import vfd_pkg::*;
#(
  parameter int NDIG = DIGITS,
  parameter int NGRP = GROUPS,
  parameter int BW   = BYTE_W,
  localparam int SEGW = NGRP * BW,
  localparam int SW   = $clog2(NDIG + 1),
  localparam int GW   = $clog2(NGRP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_en,
  input  logic [GW-1:0]   fetch_grp,
  input  logic [BW-1:0]   fetch_data,
  input  logic            tick,
  input  logic [SW-1:0]   nxt_slot,
  input  logic [SEGW-1:0] port_lat,
  output logic [SEGW-1:0] seg_o,
  output logic [NDIG-1:0] dig_o,
  output logic            key_o,
  output logic [SEGW-1:0] pin_o
);
  localparam logic [SW-1:0] KEY_SLOT = SW'(NDIG);

  logic [SEGW-1:0] shadow;

  for (genvar g = 0; g < NGRP; g++) begin : g_shadow
    logic [BW-1:0] sh_byte;
    always_ff @(posedge clk) begin
      if (rst) sh_byte <= '0;
      else if (fetch_en && fetch_grp == GW'(g)) sh_byte <= fetch_data;
    end
    assign shadow[g*BW +: BW] = sh_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_o <= '0;
      dig_o <= '0;
      key_o <= 1'b0;
    end else if (tick) begin
      if (nxt_slot == KEY_SLOT) begin
        seg_o <= '0;
        dig_o <= '0;
        key_o <= 1'b1;
      end else begin
        seg_o <= shadow;
        dig_o <= NDIG'(1) << nxt_slot;
        key_o <= 1'b0;
      end
    end
  end

  assign pin_o = key_o ? port_lat : seg_o;

  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dig_o));

  p_key_then_t0_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(key_o) |-> dig_o[0]);

  p_key_blank_r5: assert property (@(posedge clk) disable iff (rst)
    key_o |-> (seg_o == '0) && (dig_o == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(seg_o) && $stable(dig_o));
endmodule

// File: rtl/vfd_scan_top.sv
module vfd_scan_top
  import vfd_pkg::*;
#(
  parameter int NDIG = DIGITS,
  parameter int NGRP = GROUPS,
  parameter int BW   = BYTE_W,
  parameter int AW   = ADDR_W,
  parameter int CW   = CNT_W,
  parameter logic [15:0] BASE = RAM_BASE,
  localparam int SEGW = NGRP * BW,
  localparam int SW   = $clog2(NDIG + 1),
  localparam int GW   = $clog2(NGRP),
  localparam int DW   = $clog2(NDIG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   slot_len,
  input  logic [SEGW-1:0] port_lat,
  input  logic            cpu_valid,
  output logic            cpu_ready,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [BW-1:0]   cpu_wdata,
  output logic            cpu_rvalid,
  output logic [BW-1:0]   cpu_rdata,
  output logic [SEGW-1:0] seg_o,
  output logic [NDIG-1:0] dig_o,
  output logic            key_o,
  output logic [SEGW-1:0] pin_o
);
  logic          tick;
  logic [SW-1:0] nxt_slot;
  logic          fetch_en;
  logic [GW-1:0] fetch_grp;
  logic [BW-1:0] fetch_data;

  vfd_slot_timer #(.NDIG(NDIG), .NGRP(NGRP), .CW(CW)) u_timer (
    .clk(clk), .rst(rst), .slot_len(slot_len), .tick(tick),
    .nxt_slot(nxt_slot), .fetch_en(fetch_en), .fetch_grp(fetch_grp)
  );

  vfd_disp_ram #(.NDIG(NDIG), .NGRP(NGRP), .AW(AW), .BW(BW), .BASE(BASE)) u_ram (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .fetch_en(fetch_en),
    .fetch_grp(fetch_grp), .fetch_dig(nxt_slot[DW-1:0]), .fetch_data(fetch_data)
  );

  vfd_seg_latch #(.NDIG(NDIG), .NGRP(NGRP), .BW(BW)) u_latch (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .fetch_grp(fetch_grp),
    .fetch_data(fetch_data), .tick(tick), .nxt_slot(nxt_slot),
    .port_lat(port_lat), .seg_o(seg_o), .dig_o(dig_o), .key_o(key_o),
    .pin_o(pin_o)
  );
endmodule

// File: tb/vfd_scan_top_test.sv
`timescale 1ns/1ps
module vfd_scan_top_test;
  typedef struct packed {
    logic [39:0] seg;
    logic [15:0] dig;
    logic        key;
    logic [39:0] pin;
  } exp_t;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  slot_len = 8'd7;
  logic [39:0] port_lat = 40'hA5C35A3C96;
  logic        cpu_valid = 0, cpu_we = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid, key_o;
  logic [7:0]  cpu_rdata;
  logic [39:0] seg_o, pin_o;
  logic [15:0] dig_o;

  int   nchk = 0, nfail = 0;
  logic [7:0] mdl [80];
  exp_t sbq [$];
  bit   armed = 0, started = 0;
  logic [16:0] prev_kd;
  int   len = 0, len_exp = 8;

  vfd_scan_top uut (
    .clk(clk), .rst(rst), .slot_len(slot_len), .port_lat(port_lat),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .seg_o(seg_o), .dig_o(dig_o), .key_o(key_o),
    .pin_o(pin_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic exp_t mk(input int n);
    exp_t e;
    if (n == 16) begin
      e.seg = '0; e.dig = '0; e.key = 1'b1; e.pin = port_lat;
    end else begin
      for (int g = 0; g < 5; g++) e.seg[g*8 +: 8] = mdl[16*g + n];
      e.dig = 16'(1) << n; e.key = 1'b0; e.pin = e.seg;
    end
    return e;
  endfunction

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    logic ok;
    @(negedge clk);
    cpu_valid = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    do begin ok = cpu_ready; @(posedge clk); end while (!ok);
    @(negedge clk);
    cpu_valid = 0; cpu_we = 0;
  endtask

  task automatic cpu_rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    logic ok;
    @(negedge clk);
    cpu_valid = 1; cpu_we = 0; cpu_addr = a;
    do begin ok = cpu_ready; @(posedge clk); end while (!ok);
    @(negedge clk);
    cpu_valid = 0;
    chk(cpu_rvalid && cpu_rdata == exp, req, {cpu_rvalid, cpu_rdata}, {1'b1, exp});
  endtask

  task automatic wait_dig(input logic [15:0] d);
    do begin @(posedge clk); #1; end while (dig_o != d);
  endtask

  task automatic load_all();
    for (int i = 0; i < 80; i++) cpu_wr(16'hFA30 + 16'(i), mdl[i]);
  endtask

  // driver: push one expected item per slot, then arm the monitor
  task automatic run_frames(input int nfr, input int slen);
    wait_dig(16'h8000);
    for (int f = 0; f < nfr; f++) begin
      sbq.push_back(mk(16));
      for (int n = 0; n < 16; n++) sbq.push_back(mk(n));
    end
    prev_kd = {key_o, dig_o}; started = 0; len_exp = slen; armed = 1;
    while (sbq.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1 armed = 0;
  endtask

  // monitor: compare each slot at its first cycle; model the fetch window
  always @(negedge clk) begin
    if (armed) begin
      if ({key_o, dig_o} != prev_kd) begin
        prev_kd = {key_o, dig_o};
        if (started) chk(len == len_exp, "R2 slot length", 64'(len), 64'(len_exp));
        started = 1; len = 1;
        if (sbq.size() > 0) begin
          exp_t e;
          e = sbq.pop_front();
          chk(dig_o == e.dig && key_o == e.key, "R3 digit order",
              {key_o, dig_o}, {e.key, e.dig});
          chk(seg_o == e.seg, "R4 segment bytes", seg_o, e.seg);
          chk(pin_o == e.pin, "R5 shared pins", pin_o, e.pin);
        end
      end else len++;
      if (started) begin
        bit fetching;
        fetching = (len <= 5) && (dig_o != 16'h8000);
        chk(cpu_ready == !fetching, "R6 fetch priority", 64'(cpu_ready), 64'(!fetching));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] old;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(seg_o == 0 && dig_o == 0 && !key_o && pin_o == 0 && !cpu_rvalid,
        "R1 reset state", {key_o, dig_o, seg_o}, 0);
    rst = 0;
    @(negedge clk);
    chk(dig_o == 0 && pin_o == 0, "R1 blank before first boundary", pin_o, 0);
    wait_dig(16'h0001);
    chk(!key_o, "R1 first slot is T0", 64'(key_o), 0);

    for (int i = 0; i < 80; i++) mdl[i] = 8'((i * 37 + 11) ^ (i << 3));
    load_all();
    cpu_rd(16'hFA30, mdl[0], "R7 readback");
    cpu_rd(16'hFA5B, mdl[43], "R7 readback");
    cpu_rd(16'hFA7F, mdl[79], "R7 readback");
    cpu_wr(16'hFA80, 8'h77);
    cpu_wr(16'hFA2F, 8'h66);
    cpu_rd(16'hFA80, 8'h00, "R9 out of range read");
    cpu_rd(16'hFA2F, 8'h00, "R9 out of range read");
    cpu_rd(16'hFA30, mdl[0], "R9 no aliasing");
    cpu_rd(16'hFA7F, mdl[79], "R9 no aliasing");

    // collision: read request held valid through two frames
    @(negedge clk);
    cpu_valid = 1; cpu_we = 0; cpu_addr = 16'hFA30;
    run_frames(2, 8);
    @(negedge clk);
    cpu_valid = 0;

    // shortest slot: length clamps to 6 cycles
    slot_len = 8'd2;
    for (int i = 0; i < 80; i++) mdl[i] = ~mdl[i];
    load_all();
    run_frames(1, 6);

    // shadow isolation
    slot_len = 8'd30;
    wait_dig(16'h0010);
    wait_dig(16'h0020);
    repeat (8) @(posedge clk);
    old = mdl[5];
    cpu_wr(16'hFA35, ~old);
    chk(dig_o == 16'h0020 && seg_o[7:0] == old, "R8 shadow holds",
        {dig_o, seg_o[7:0]}, {16'h0020, old});
    mdl[5] = ~old;
    wait_dig(16'h0010);
    wait_dig(16'h0020);
    chk(seg_o[7:0] == mdl[5] && seg_o[15:8] == mdl[21], "R4 new byte shown",
        seg_o[15:0], {mdl[21], mdl[5]});

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule